// File: doc/BRIEF.md
# Complement bank with a rationed number of NOT stages

This block returns the bitwise complement of a small input word. It uses only monotone AND/OR logic plus a fixed, minimal number of explicit NOT stages: two stages for a 3-bit word and three stages for a 7-bit word. A compile-time parameter picks the word width.

Each NOT stage inverts a monotone count-class signal over the inputs: at-least-half, the second bit of the population count, and parity. A later stage may take an earlier stage's output as its input. Every output bit is then rebuilt as an OR of AND terms. These terms combine the inverted class signals with monotone threshold terms over the other input bits.

The block is purely combinational and holds no state. The only NOT operator in the design sits inside a dedicated inverter cell, so the number of NOT stages is visible in the hierarchy. The block also reports that number on an output port.

Top module: `sparse_not_bank`

## Requirements
- R1: With WIDTH=7, every bit of `q` equals the inverse of the same bit of `d`, for all 128 input patterns.
- R2: With WIDTH=3, every bit of `q` equals the inverse of the same bit of `d`, for all 8 input patterns.
- R3: With WIDTH=3, the design contains exactly two inverter cells, and `not_stages` reads 2.
- R4: With WIDTH=7, the design contains exactly three inverter cells, and `not_stages` reads 3.
- R5: With WIDTH=3, the NOT stages have these outputs:
  - The first stage output is high exactly when at most one input bit is high.
  - The second stage output is high exactly when the count of high input bits is even.
- R6: With WIDTH=7, let c be the count of high input bits. The NOT stages have these outputs:
  - The first stage output is high exactly when c is at most 3.
  - The second is high exactly when c mod 4 is 0 or 1.
  - The third is high exactly when c is even.
- R7: An all-zero `d` gives an all-one `q`, and an all-one `d` gives an all-zero `q`, for both widths.
- R8: A one-hot or one-cold `d` gives the exactly inverted one-cold or one-hot `q`. Each bit of `q` follows only the bit of `d` at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d | input | WIDTH | Input word to be complemented |
| q | output | WIDTH | Bitwise complement of `d` |
| not_stages | output | 2 | Number of inverter cells used by the selected variant |

## Verification
A stage that settles to the wrong class value flips `q` at once. It does so for every input pattern whose population count falls in the affected class, not just for one bit position. A fault in one threshold term shows up only at counts near that threshold, and only on output bits whose own input is low. For this reason every pattern of each width is applied, rather than a sample. Because the block holds no state, each error is visible in the same cycle the pattern is applied. It is checked half a clock later.

// File: rtl/sparse_not_pkg.sv
package sparse_not_pkg;

    localparam int unsigned TRIO_STAGES   = 2;
    localparam int unsigned SEPTET_STAGES = 3;
    localparam int unsigned STAGE_CNT_W   = 2;

    // Remove bit position idx from a 7-bit word, keeping the rest in order.
    function automatic logic [5:0] others_of7(input logic [6:0] v, input int idx);
        logic [5:0] r;
        int         p;
        r = '0;
        p = 0;
        for (int j = 0; j < 7; j++) begin
            if (j != idx) begin
                r[p] = v[j];
                p++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/not_cell.sv
// The single place in the design where a logical NOT is applied.
module not_cell (
    input  logic a,
    output logic y
);
    assign y = ~a;
endmodule

// File: rtl/mono_thresh.sv
// Monotone threshold ladder: ge[k] is high when at least k bits of x are high.
// Built purely from AND/OR: row j absorbs input bit j.
module mono_thresh #(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0] x,
    output logic [W:0]   ge
);
    localparam int unsigned LAST = W - 1;

    for (genvar j = 0; j < W; j++) begin : g_step
        logic [W:0] prev_d;
        logic [W:0] row_d;
        if (j == 0) begin : g_first
            assign prev_d = (W + 1)'(1);
        end else begin : g_next
            assign prev_d = g_step[j-1].row_d;
        end
        always_comb begin
            row_d[0] = 1'b1;
            for (int k = 1; k <= W; k++) begin
                row_d[k] = prev_d[k] | (prev_d[k-1] & x[j]);
            end
        end
    end

    assign ge = g_step[LAST].row_d;

    always_comb begin
        for (int k = 0; k <= W; k++) begin
            a_r8_thresh_ladder: assert (ge[k] == ($countones(x) >= k));
        end
    end
endmodule

// File: rtl/trio_core.sv
module trio_core
    import sparse_not_pkg::*;
(
    input  logic [2:0]             d,
    output logic [2:0]             q,
    output logic [STAGE_CNT_W-1:0] stage_cnt
);
    logic maj_d, few_hi_d;   // few_hi_d: at most one input high
    logic odd_d, even_hi_d;  // even_hi_d: even count high (odd count low)

    assign maj_d = (d[0] & d[1]) | (d[0] & d[2]) | (d[1] & d[2]);
    not_cell u_stage_a (.a(maj_d), .y(few_hi_d));

    assign odd_d = ((d[0] | d[1] | d[2]) & few_hi_d) | (d[0] & d[1] & d[2]);
    not_cell u_stage_b (.a(odd_d), .y(even_hi_d));

    for (genvar i = 0; i < 3; i++) begin : g_bit
        logic o1, o2;
        assign o1 = d[(i + 1) % 3];
        assign o2 = d[(i + 2) % 3];
        assign q[i] = (few_hi_d & even_hi_d)
                    | (few_hi_d & (o1 | o2))
                    | (even_hi_d & o1 & o2);
    end

    assign stage_cnt = STAGE_CNT_W'(TRIO_STAGES);

    always_comb begin
        a_r5_stage_a: assert (few_hi_d == ($countones(d) <= 1));
        a_r5_stage_b: assert (even_hi_d == ($countones(d) % 2 == 0));
    end
endmodule

// File: rtl/septet_core.sv
module septet_core
    import sparse_not_pkg::*;
(
    input  logic [6:0]             d,
    output logic [6:0]             q,
    output logic [STAGE_CNT_W-1:0] stage_cnt
);
    logic [7:0] ge_all;
    logic       hi4_d, inv1_d;  // inv1_d: count <= 3
    logic       two_d, inv2_d;  // two_d: count in {2,3,6,7}
    logic       odd_d, inv3_d;  // inv3_d: count even

    mono_thresh #(.W(7)) u_all (.x(d), .ge(ge_all));

    assign hi4_d = ge_all[4];
    not_cell u_stage_1 (.a(hi4_d), .y(inv1_d));

    assign two_d = (ge_all[2] & inv1_d) | ge_all[6];
    not_cell u_stage_2 (.a(two_d), .y(inv2_d));

    assign odd_d = (ge_all[1] & inv1_d & inv2_d)
                 | (ge_all[3] & inv1_d)
                 | (ge_all[5] & inv2_d)
                 | ge_all[7];
    not_cell u_stage_3 (.a(odd_d), .y(inv3_d));

    for (genvar i = 0; i < 7; i++) begin : g_bit
        logic [5:0] rest_d;
        logic [6:0] ge_rest;
        assign rest_d = others_of7(d, i);
        mono_thresh #(.W(6)) u_rest (.x(rest_d), .ge(ge_rest));
        assign q[i] = (inv1_d & inv2_d & inv3_d)
                    | (inv1_d & inv2_d & ge_rest[1])
                    | (inv1_d & inv3_d & ge_rest[2])
                    | (inv1_d & ge_rest[3])
                    | (inv2_d & inv3_d & ge_rest[4])
                    | (inv2_d & ge_rest[5])
                    | (inv3_d & ge_rest[6]);
    end

    assign stage_cnt = STAGE_CNT_W'(SEPTET_STAGES);

    always_comb begin
        a_r6_stage_1: assert (inv1_d == ($countones(d) <= 3));
        a_r6_stage_2: assert (inv2_d == (($countones(d) % 4) <= 1));
        a_r6_stage_3: assert (inv3_d == ($countones(d) % 2 == 0));
    end
endmodule

// File: rtl/sparse_not_bank.sv
module sparse_not_bank
    import sparse_not_pkg::*;
#(
    parameter int unsigned WIDTH = 7
) (
    input  logic [WIDTH-1:0]       d,
    output logic [WIDTH-1:0]       q,
    output logic [STAGE_CNT_W-1:0] not_stages
);
    if (WIDTH == 7) begin : g_septet
        septet_core u_core (.d(d), .q(q), .stage_cnt(not_stages));
    end else begin : g_trio
        trio_core u_core (.d(d), .q(q), .stage_cnt(not_stages));
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            a_r1_complement: assert (q[i] != d[i]);  // R1 (WIDTH=7), R2 (WIDTH=3)
        end
        if (d == '0) begin
            a_r7_all_zero: assert (q == '1);
        end
    end
endmodule

// File: tb/sparse_not_bank_bench.sv
module sparse_not_bank_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] d7;
    logic [6:0] q7;
    logic [1:0] ns7;
    logic [2:0] d3;
    logic [2:0] q3;
    logic [1:0] ns3;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sparse_not_bank #(.WIDTH(7)) u_sparse_not_bank   (.d(d7), .q(q7), .not_stages(ns7));
    sparse_not_bank #(.WIDTH(3)) u_sparse_not_bank_3 (.d(d3), .q(q3), .not_stages(ns3));

    function automatic logic [6:0] exp7(input logic [6:0] v);
        logic [6:0] r;
        for (int i = 0; i < 7; i++) r[i] = (v[i] == 1'b0);
        return r;
    endfunction

    function automatic logic [2:0] exp3(input logic [2:0] v);
        logic [2:0] r;
        for (int i = 0; i < 3; i++) r[i] = (v[i] == 1'b0);
        return r;
    endfunction

    task automatic apply7(input logic [6:0] v, input string tag);
        @(posedge clk);
        d7 = v;
        @(negedge clk);
        n_tests++;
        if (q7 !== exp7(v)) begin
            n_fail++;
            $display("FAIL %s d=%b q=%b expected=%b", tag, v, q7, exp7(v));
        end
    endtask

    task automatic apply3(input logic [2:0] v, input string tag);
        @(posedge clk);
        d3 = v;
        @(negedge clk);
        n_tests++;
        if (q3 !== exp3(v)) begin
            n_fail++;
            $display("FAIL %s d=%b q=%b expected=%b", tag, v, q3, exp3(v));
        end
    endtask

    initial begin
        d7 = '0;
        d3 = '0;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R7: initial all-zero pattern, then all-one
        apply7(7'h00, "R7 w7 zeros");
        apply7(7'h7f, "R7 w7 ones");
        apply3(3'b000, "R7 w3 zeros");
        apply3(3'b111, "R7 w3 ones");

        // R3, R4: stage counts reported at the ports
        n_tests++;
        if (ns3 !== 2'd2) begin
            n_fail++;
            $display("FAIL R3 not_stages=%0d expected=2", ns3);
        end
        n_tests++;
        if (ns7 !== 2'd3) begin
            n_fail++;
            $display("FAIL R4 not_stages=%0d expected=3", ns7);
        end

        // R8: walking one-hot and one-cold patterns
        for (int i = 0; i < 7; i++) begin
            apply7(7'(1) << i, "R8 w7 onehot");
            apply7(~(7'(1) << i), "R8 w7 onecold");
        end
        for (int i = 0; i < 3; i++) begin
            apply3(3'(1) << i, "R8 w3 onehot");
            apply3(~(3'(1) << i), "R8 w3 onecold");
        end

        // R1, R6: exhaustive sweep of 7-bit width
        for (int v = 0; v < 128; v++) apply7(7'(v), "R1 R6 w7 sweep");
        // R2, R5: exhaustive sweep of 3-bit width
        for (int v = 0; v < 8; v++) apply3(3'(v), "R2 R5 w3 sweep");

        // R1, R2: seeded random patterns
        for (int n = 0; n < 200; n++) begin
            apply7(7'($urandom), "R1 w7 random");
            apply3(3'($urandom), "R2 w3 random");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule